// File: doc/BRIEF.md
# Variable-Field Speech Frame Packer

This block turns one frame of compressed speech into a byte stream. A frame opens with a one-byte code for the noise floor. Next come eight 4-bit bit-allocation fields, one per band. Last come the quantized levels of fourteen blocks, band by band inside each block. A level field is exactly as wide as its band's allocation, so a reader has to take in the header before it can split up the levels. Frame length therefore depends on the allocations: between 40 and 1720 bits with the default parameters.

The noise floor arrives as a positive linear value. The block compresses it to an 8-bit code made of a 4-bit exponent and a 4-bit mantissa. The sign is not sent, since it is always positive. The mantissa's leading one is not sent, since it is always set. A frame starts with a one-cycle start strobe, which captures the floor and the allocations. While a frame is running, the packer reads levels from an upstream buffer through a zero-latency index/data port. Finished bytes go to a memory writer over a ready/valid handshake. A done pulse marks the end of each frame.

Top module: `spk_frame_packer`

## Requirements
- R1: After reset, `byteValid`, `lvlRd` and `frameDone` are all low.
- R2: The first byte of a frame is `{exp[3:0], man[3:0]}`. `exp` is the bit position of the highest set bit of the floor. `man` is the four bits just below that bit, truncated, with zeros filling in below bit 0. A floor of zero codes as 8'h00.
- R3: Bits 8 to 39 of a frame hold the allocations for band 0 up to band 7, 4 bits each. Band k comes from `allocIn[4k+3:4k]`.
- R4: After the allocations come the levels for block 0 up to block 13, with band 0 up to band 7 inside each block. Each level field is the low `alloc[band]` bits of `lvlData`. A band with an allocation of zero adds no bits.
- R5: Every field is sent MSB first, and bits fill each byte from bit 7 down to bit 0. The last byte is padded with zeros, so a frame takes ceil(bits/8) bytes.
- R6: While `byteValid` is high and `byteReady` is low, `byteValid` stays high and `byteData` does not change on the next cycle. No byte is lost or repeated under backpressure.
- R7: A `frameStart` that arrives while a frame is running is ignored.
- R8: `frameDone` is high for exactly one cycle, after the last byte has been handed off. While it is high, `byteValid` and `lvlRd` are low.
- R9: The floor and the allocations are captured at start. Changes to `floorIn` or `allocIn` during a frame do not alter that frame.
- R10: While `lvlRd` is high, `lvlBlk`/`lvlBand` give the level being fetched and `lvlData` is sampled in that same cycle. The first fetch of a frame is block 0, band 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Start strobe, accepted only when idle |
| floorIn | input | 16 | Linear noise floor |
| allocIn | input | 32 | Per-band bit allocations, 4 bits each |
| lvlRd | output | 1 | Level fetch in progress |
| lvlBlk | output | 4 | Block index of the fetched level |
| lvlBand | output | 3 | Band index of the fetched level |
| lvlData | input | 15 | Level value for the presented index |
| byteData | output | 8 | Packed output byte |
| byteValid | output | 1 | Output byte valid |
| byteReady | input | 1 | Memory writer accepts byte |
| frameDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
The handoff of a byte and the insertion of a new field can land in the same cycle. In that cycle the bit count is lowered by eight and raised by the field width at once, and the new bits go in below the byte being taken. This is provoked with dense, wide allocations and random `byteReady` backpressure at several stall rates. The byte stream is then compared bit-exactly against a reference frame that the bench builds from the requirements. Short frames with all-zero and single-bit allocations cover the padding path and the path where no levels are sent.

// File: rtl/spk_pkg.sv
package spk_pkg;

  typedef enum logic [1:0] {
    FLD_FLOOR,
    FLD_ALLOC,
    FLD_LEVEL,
    FLD_PAD
  } fieldKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       push;
    fieldKind_e kind;
  } pkCtrl_t;

endpackage

// File: rtl/spk_pack_ctrl.sv
module spk_pack_ctrl
  import spk_pkg::*;
#(
  parameter int NBANDS  = 8,
  parameter int NBLOCKS = 14,
  localparam int BAND_IW = (NBANDS  > 1) ? $clog2(NBANDS)  : 1,
  localparam int BLK_IW  = (NBLOCKS > 1) ? $clog2(NBLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              pushOk,
  input  logic              accPartial,
  input  logic              accEmpty,
  output pkCtrl_t           ctl,
  output logic [BAND_IW-1:0] bandIdx,
  output logic [BLK_IW-1:0]  blkIdx,
  output logic              lvlRd,
  output logic              doneOut
);

  localparam logic [BAND_IW-1:0] LAST_BAND = BAND_IW'(NBANDS - 1);
  localparam logic [BLK_IW-1:0]  LAST_BLK  = BLK_IW'(NBLOCKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_FLOOR, S_ALLOC, S_LEVEL, S_FLUSH, S_DONE} state_e;

  state_e state, nState;
  logic [BAND_IW-1:0] bandN;
  logic [BLK_IW-1:0]  blkN;

  always_comb begin
    ctl    = '0;
    nState = state;
    bandN  = bandIdx;
    blkN   = blkIdx;
    unique case (state)
      S_IDLE: if (startIn) begin
        ctl.load = 1'b1;
        nState   = S_FLOOR;
      end
      S_FLOOR: begin
        ctl.push = 1'b1;
        ctl.kind = FLD_FLOOR;
        if (pushOk) begin
          nState = S_ALLOC;
          bandN  = '0;
        end
      end
      S_ALLOC: begin
        ctl.push = 1'b1;
        ctl.kind = FLD_ALLOC;
        if (pushOk) begin
          if (bandIdx == LAST_BAND) begin
            bandN  = '0;
            blkN   = '0;
            nState = S_LEVEL;
          end else begin
            bandN = bandIdx + 1'b1;
          end
        end
      end
      S_LEVEL: begin
        ctl.push = 1'b1;
        ctl.kind = FLD_LEVEL;
        if (pushOk) begin
          if (bandIdx == LAST_BAND) begin
            bandN = '0;
            if (blkIdx == LAST_BLK) nState = S_FLUSH;
            else                    blkN   = blkIdx + 1'b1;
          end else begin
            bandN = bandIdx + 1'b1;
          end
        end
      end
      S_FLUSH: begin
        if (accPartial) begin
          ctl.push = 1'b1;
          ctl.kind = FLD_PAD;
        end else if (accEmpty) begin
          nState = S_DONE;
        end
      end
      S_DONE:  nState = S_IDLE;
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bandIdx <= '0;
      blkIdx  <= '0;
    end else begin
      state   <= nState;
      bandIdx <= bandN;
      blkIdx  <= blkN;
    end
  end

  assign lvlRd   = (state == S_LEVEL);
  assign doneOut = (state == S_DONE);

endmodule

// File: rtl/spk_pack_dp.sv
module spk_pack_dp
  import spk_pkg::*;
#(
  parameter int FLOOR_W = 16,
  parameter int NBANDS  = 8,
  parameter int ALLOC_W = 4,
  localparam int LVL_W   = (1 << ALLOC_W) - 1,
  localparam int BAND_IW = (NBANDS > 1) ? $clog2(NBANDS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pkCtrl_t                   ctl,
  input  logic [BAND_IW-1:0]        bandIdx,
  input  logic [FLOOR_W-1:0]        floorIn,
  input  logic [NBANDS*ALLOC_W-1:0] allocIn,
  input  logic [LVL_W-1:0]          lvlData,
  input  logic                      outReady,
  output logic [7:0]                outData,
  output logic                      outValid,
  output logic                      pushOk,
  output logic                      accPartial,
  output logic                      accEmpty
);

  localparam int MAXF  = (LVL_W > 8) ? LVL_W : 8;
  localparam int ACC_W = 8 + MAXF;
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam logic [CNT_W-1:0] EIGHT   = CNT_W'(8);
  localparam logic [CNT_W-1:0] SIXTEEN = CNT_W'(16);

  logic [7:0]                            codeReg;
  logic [NBANDS-1:0][ALLOC_W-1:0]        allocReg;
  logic [ACC_W-1:0]                      acc;
  logic [CNT_W-1:0]                      cnt;
  logic [CNT_W-1:0]                      fieldW;
  logic [ACC_W-1:0]                      fieldV, fieldMask;
  logic                                  pop, doPush;

  // exponent = top set bit, mantissa = next four bits, truncated
  function automatic logic [7:0] floorCode(input logic [FLOOR_W-1:0] f);
    int e;
    logic [FLOOR_W-1:0] norm;
    e = -1;
    for (int i = 0; i < FLOOR_W; i++) if (f[i]) e = i;
    if (e < 0) return 8'h00;
    norm = f << (FLOOR_W - 1 - e);
    return {4'(e), norm[FLOOR_W-2 -: 4]};
  endfunction

  always_comb begin
    unique case (ctl.kind)
      FLD_FLOOR: begin fieldW = EIGHT;                    fieldV = ACC_W'(codeReg);            end
      FLD_ALLOC: begin fieldW = CNT_W'(ALLOC_W);          fieldV = ACC_W'(allocReg[bandIdx]);  end
      FLD_LEVEL: begin fieldW = CNT_W'(allocReg[bandIdx]); fieldV = ACC_W'(lvlData);            end
      default:   begin fieldW = EIGHT - cnt;              fieldV = '0;                         end
    endcase
  end

  assign fieldMask  = (ACC_W'(1) << fieldW) - ACC_W'(1);
  assign outValid   = (cnt >= EIGHT);
  assign outData    = 8'(acc >> (cnt - EIGHT));
  assign pop        = outValid && outReady;
  assign pushOk     = (cnt < EIGHT) || (pop && (cnt < SIXTEEN));
  assign doPush     = ctl.push && pushOk;
  assign accEmpty   = (cnt == '0);
  assign accPartial = (cnt != '0) && (cnt < EIGHT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg  <= '0;
      allocReg <= '0;
      acc      <= '0;
      cnt      <= '0;
    end else begin
      if (ctl.load) begin
        codeReg  <= floorCode(floorIn);
        allocReg <= allocIn;
      end
      if (doPush) acc <= (acc << fieldW) | (fieldV & fieldMask);
      cnt <= cnt - (pop ? EIGHT : '0) + (doPush ? fieldW : '0);
    end
  end

endmodule

// File: rtl/spk_frame_packer.sv
module spk_frame_packer
  import spk_pkg::*;
#(
  parameter int FLOOR_W = 16,
  parameter int NBANDS  = 8,
  parameter int NBLOCKS = 14,
  parameter int ALLOC_W = 4,
  localparam int LVL_W   = (1 << ALLOC_W) - 1,
  localparam int BAND_IW = (NBANDS  > 1) ? $clog2(NBANDS)  : 1,
  localparam int BLK_IW  = (NBLOCKS > 1) ? $clog2(NBLOCKS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frameStart,
  input  logic [FLOOR_W-1:0]        floorIn,
  input  logic [NBANDS*ALLOC_W-1:0] allocIn,
  output logic                      lvlRd,
  output logic [BLK_IW-1:0]         lvlBlk,
  output logic [BAND_IW-1:0]        lvlBand,
  input  logic [LVL_W-1:0]          lvlData,
  output logic [7:0]                byteData,
  output logic                      byteValid,
  input  logic                      byteReady,
  output logic                      frameDone
);

  pkCtrl_t ctl;
  logic    pushOk, accPartial, accEmpty;

  spk_pack_ctrl #(.NBANDS(NBANDS), .NBLOCKS(NBLOCKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(frameStart),
    .pushOk(pushOk), .accPartial(accPartial), .accEmpty(accEmpty),
    .ctl(ctl), .bandIdx(lvlBand), .blkIdx(lvlBlk),
    .lvlRd(lvlRd), .doneOut(frameDone)
  );

  spk_pack_dp #(.FLOOR_W(FLOOR_W), .NBANDS(NBANDS), .ALLOC_W(ALLOC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bandIdx(lvlBand),
    .floorIn(floorIn), .allocIn(allocIn), .lvlData(lvlData),
    .outReady(byteReady), .outData(byteData), .outValid(byteValid),
    .pushOk(pushOk), .accPartial(accPartial), .accEmpty(accEmpty)
  );

endmodule

// File: rtl/spk_frame_packer_chk.sv
module spk_frame_packer_chk #(
  parameter int FLOOR_W = 16,
  parameter int NBANDS  = 8,
  parameter int NBLOCKS = 14,
  parameter int ALLOC_W = 4,
  localparam int LVL_W   = (1 << ALLOC_W) - 1,
  localparam int BAND_IW = (NBANDS  > 1) ? $clog2(NBANDS)  : 1,
  localparam int BLK_IW  = (NBLOCKS > 1) ? $clog2(NBLOCKS) : 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      frameStart,
  input logic [FLOOR_W-1:0]        floorIn,
  input logic [NBANDS*ALLOC_W-1:0] allocIn,
  input logic                      lvlRd,
  input logic [BLK_IW-1:0]         lvlBlk,
  input logic [BAND_IW-1:0]        lvlBand,
  input logic [LVL_W-1:0]          lvlData,
  input logic [7:0]                byteData,
  input logic                      byteValid,
  input logic                      byteReady,
  input logic                      frameDone
);

  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !byteReady |=> byteValid && $stable(byteData)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R8

  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !byteValid && !lvlRd); // R8

  AST_LVL_BLK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    lvlRd |-> (int'(lvlBlk) < NBLOCKS)); // R10

  AST_LVL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lvlRd) |-> (lvlBlk == '0) && (lvlBand == '0)); // R4

endmodule

bind spk_frame_packer spk_frame_packer_chk #(
  .FLOOR_W(FLOOR_W), .NBANDS(NBANDS), .NBLOCKS(NBLOCKS), .ALLOC_W(ALLOC_W)
) u_chk (.*);

// File: tb/spk_frame_packer_bench.sv
`timescale 1ns/1ps
module spk_frame_packer_bench;

  localparam int FLOOR_W = 16;
  localparam int NBANDS  = 8;
  localparam int NBLOCKS = 14;
  localparam int ALLOC_W = 4;
  localparam int LVL_W   = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic [15:0] floorIn = '0;
  logic [31:0] allocIn = '0;
  logic        lvlRd;
  logic [3:0]  lvlBlk;
  logic [2:0]  lvlBand;
  logic [14:0] lvlData;
  logic [7:0]  byteData;
  logic        byteValid;
  logic        byteReady = 1'b0;
  logic        frameDone;

  always #2.5 clk = ~clk;

  spk_frame_packer u_spk_frame_packer (.*);

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] salt = 32'h1;
  int stallPct = 0;
  bit monOn = 1'b0;
  int doneCnt = 0;
  bit doneLast = 1'b0;
  bit prevStall = 1'b0;
  logic [7:0] prevData = '0;
  logic [7:0] got[$];
  logic [7:0] expQ[$];

  function automatic logic [14:0] lvlFn(input logic [31:0] s, input int b, input int k);
    logic [31:0] h;
    h = s ^ (32'(b) * 32'h0001_0193) ^ (32'(k) * 32'h2545_F491);
    h = h * 32'h9E37_79B1;
    return h[26:12];
  endfunction

  always_comb lvlData = lvlFn(salt, int'(lvlBlk), int'(lvlBand));

  function automatic logic [7:0] expFloor(input logic [15:0] f);
    int e;
    int m;
    e = -1;
    for (int i = 0; i < 16; i++) if (f[i]) e = i;
    if (e < 0) return 8'h00;
    if (e >= 4) m = int'(f >> (e - 4)) & 15;
    else        m = int'(f << (4 - e)) & 15;
    return {4'(e), 4'(m)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic buildExp(input logic [15:0] f, input logic [31:0] al);
    bit bits[$];
    logic [7:0] code;
    logic [14:0] lv;
    int w;
    code = expFloor(f);
    for (int i = 7; i >= 0; i--) bits.push_back(code[i]);
    for (int k = 0; k < NBANDS; k++)
      for (int i = 3; i >= 0; i--) bits.push_back(al[4*k+i]);
    for (int b = 0; b < NBLOCKS; b++)
      for (int k = 0; k < NBANDS; k++) begin
        w = int'(al[4*k +: 4]);
        lv = lvlFn(salt, b, k);
        for (int i = w - 1; i >= 0; i--) bits.push_back(lv[i]);
      end
    while (bits.size() % 8 != 0) bits.push_back(1'b0);
    expQ.delete();
    for (int j = 0; j < bits.size(); j += 8) begin
      logic [7:0] by;
      for (int i = 0; i < 8; i++) by[7-i] = bits[j+i];
      expQ.push_back(by);
    end
  endtask

  // output monitor: drive ready, record handshakes, judge stalls and done
  always @(negedge clk) begin
    if (monOn) begin
      if (prevStall)
        chk(byteValid && byteData == prevData, "R6", "stalled byte changed",
            {byteValid, byteData}, {1'b1, prevData});
      byteReady = ($urandom % 100) >= stallPct;
      if (byteValid && byteReady) got.push_back(byteData);
      prevStall = byteValid && !byteReady;
      prevData  = byteData;
      if (frameDone) begin
        doneCnt++;
        chk(!byteValid && !lvlRd, "R8", "activity during done",
            {byteValid, lvlRd}, 0);
        chk(got.size() == expQ.size(), "R8", "done before last byte",
            got.size(), expQ.size());
      end
      if (doneLast && frameDone) chk(1'b0, "R8", "done longer than one cycle", 1, 0);
      doneLast = frameDone;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      chk(1'b0, "WATCHDOG", "run hung", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic runFrame(input logic [15:0] f, input logic [31:0] al,
                          input logic [31:0] s, input int stall, input bit disturb,
                          input string tag);
    int t;
    int bad;
    salt = s;
    stallPct = stall;
    got.delete();
    doneCnt = 0;
    buildExp(f, al);
    @(negedge clk);
    floorIn = f; allocIn = al; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    if (disturb) begin
      // R7 R9: second start and new inputs while busy
      repeat (3) @(negedge clk);
      floorIn = ~f; allocIn = ~al; frameStart = 1'b1;
      @(negedge clk);
      frameStart = 1'b0;
    end
    t = 0;
    while (doneCnt == 0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(doneCnt != 0, "R8", {tag, " no done"}, doneCnt, 1);
    repeat (4) @(negedge clk);
    chk(doneCnt == 1, "R8", {tag, " done count"}, doneCnt, 1);
    chk(got.size() == expQ.size(), "R5", {tag, " byte count"}, got.size(), expQ.size());
    if (got.size() >= 1)
      chk(got[0] == expQ[0], "R2", {tag, " floor code"}, got[0], expQ[0]);
    for (int i = 1; i < 5; i++)
      if (got.size() > i)
        chk(got[i] == expQ[i], "R3", {tag, " alloc byte"}, got[i], expQ[i]);
    bad = -1;
    for (int i = 5; i < expQ.size(); i++)
      if (bad < 0 && (i >= got.size() || got[i] !== expQ[i])) bad = i;
    if (bad >= 0)
      chk(1'b0, disturb ? "R7/R9" : "R4", {tag, " level byte"},
          (bad < got.size()) ? longint'(got[bad]) : -1, expQ[bad]);
    else
      chk(1'b1, "R4", tag, 0, 0);
    if (expQ.size() > 0)
      chk(got.size() > 0 && got[got.size()-1] == expQ[expQ.size()-1], "R5",
          {tag, " last byte padding"},
          (got.size() > 0) ? longint'(got[got.size()-1]) : -1, expQ[expQ.size()-1]);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!byteValid && !lvlRd && !frameDone, "R1", "reset outputs",
        {byteValid, lvlRd, frameDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!byteValid && !lvlRd && !frameDone, "R1", "idle after reset",
        {byteValid, lvlRd, frameDone}, 0);
    monOn = 1'b1;

    // directed corners
    runFrame(16'h0013, 32'h4444_4444, 32'h11, 0,  1'b0, "R2 exp4");
    runFrame(16'h0000, 32'h0000_0000, 32'h22, 0,  1'b0, "R4 zero alloc");
    runFrame(16'hFFFF, 32'hFFFF_FFFF, 32'h33, 50, 1'b0, "R6 wide stalled");
    runFrame(16'h0001, 32'h0000_0001, 32'h44, 20, 1'b0, "R5 pad");
    runFrame(16'h0006, 32'h0F00_30A1, 32'h55, 30, 1'b1, "R7 R9 disturb");
    runFrame(16'h8000, 32'hF1F1_F1F1, 32'h66, 70, 1'b0, "R10 mixed");

    // constrained random frames
    for (int n = 0; n < 16; n++) begin
      logic [31:0] al;
      logic [15:0] f;
      for (int k = 0; k < NBANDS; k++)
        al[4*k +: 4] = (($urandom % 4) == 0) ? 4'd0 : 4'($urandom % 16);
      f = 16'($urandom) >> ($urandom % 16);
      runFrame(f, al, $urandom, int'($urandom % 80), n % 5 == 0, "random");
    end

    summary();
    $finish;
  end

endmodule